// File: doc/BRIEF.md
# Direct-Mapped Data Translation Buffer

This block holds the recent page translations of a 32-bit data address space that uses 8 KB pages. Each of its 64 entries is selected straight from the virtual address (one way, no replacement choice) and keeps a 13-bit virtual tag with a valid flag, plus a 19-bit physical page number, four access-permission bits and a cache-inhibit flag. A lookup presents a virtual address with the enable high. On the next clock edge the block reports whether the selected entry matches, along with that entry's physical page, permissions and cache-inhibit flag. These results then hold until the next enabled lookup.

Software fills and inspects the entries through a special-purpose-register port. Each entry has a tag word and a translation word, and the two kinds of word sit in separate address windows. Reads are combinational and return the addressed word rebuilt into its register layout. Bits that the block does not store read as zero. Exception generation, physical-address muxing and any bypass path belong to the surrounding logic.

Top module: `dtlb_direct`

## Requirements
- R1: After reset every entry is invalid, all lookup outputs are zero, and no lookup hits until a tag word with bit 0 set has been written.
- R2: A lookup with `lkp_en` high at a clock edge uses entry index `lkp_vaddr[18:13]`. On that edge `lkp_hit` becomes 1 when the entry is valid and its stored tag equals `lkp_vaddr[31:19]`. Page-offset bits 12..0 have no effect.
- R3: `lkp_hit` is 0 after a lookup whose tag differs from the stored one, and after a lookup of an entry whose valid flag is clear.
- R4: On the same edge, `lkp_ppn`, the four permission outputs and `lkp_ci` take the selected entry's stored fields, whether or not the lookup hits.
- R5: While `lkp_en` is low, every lookup output keeps its value, whatever `lkp_vaddr` does.
- R6: The tag word of entry i is at SPR address 0x0A00+i (i = 0..63). A write stores the tag from data bits 31..19 and the valid flag from bit 0. A read returns them in the same bit positions, with bits 18..1 zero.
- R7: The translation word of entry i is at 0x0B00+i. Its fields are: physical page in bits 31..13, supervisor write in bit 9, supervisor read in bit 8, user write in bit 7, user read in bit 6, and cache inhibit in bit 1. A read returns these fields with bits 12..10, 5..2 and 0 zero.
- R8: An SPR write changes only the addressed word of the addressed entry. The other word of that entry and all other entries are unchanged.
- R9: `spr_rdata` is zero when `spr_cs` is low, during a write, and for any address outside the two 64-word windows. A write outside the windows changes no entry.
- R10: When a lookup and an SPR write to the same entry share a clock edge, the lookup returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lkp_en | input | 1 | Lookup enable, sampled at the clock edge |
| lkp_vaddr | input | 32 | Virtual address to translate |
| lkp_hit | output | 1 | Selected entry is valid and its tag matches |
| lkp_ppn | output | 19 | Physical page number (physical address bits 31..13) |
| lkp_sup_wr | output | 1 | Supervisor write permitted |
| lkp_sup_rd | output | 1 | Supervisor read permitted |
| lkp_usr_wr | output | 1 | User write permitted |
| lkp_usr_rd | output | 1 | User read permitted |
| lkp_ci | output | 1 | Cache inhibit for the page |
| spr_cs | input | 1 | SPR chip select |
| spr_we | input | 1 | SPR write (1) or read (0) |
| spr_addr | input | 16 | SPR word address |
| spr_wdata | input | 32 | SPR write data |
| spr_rdata | output | 32 | SPR read data, combinational |

## Verification
The assertions check several properties on every cycle. The read data must be zero when idle or writing. Unstored bits of both word layouts must read as zero. Lookup outputs must not move while the enable is low. A hit may not appear before any valid tag has been written. Only the scenarios can show the rest: the tag compare against the right index bits, the field values carried per entry, a write touching only its own word, and out-of-window writes leaving entries intact. The same goes for the old-contents result when a lookup and a write to the same entry share an edge.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

  // Bit positions inside the software-visible words.
  localparam int TAGW_VALID_BIT = 0;
  localparam int XLW_CI_BIT     = 1;
  localparam int XLW_UR_BIT     = 6;
  localparam int XLW_UW_BIT     = 7;
  localparam int XLW_SR_BIT     = 8;
  localparam int XLW_SW_BIT     = 9;

  typedef struct packed {
    logic sw;
    logic sr;
    logic uw;
    logic ur;
  } perm_t;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_TAGW  = 2'd1,
    SEL_XLW   = 2'd2
  } spr_sel_e;

endpackage

// File: rtl/dtlb_spr_decode.sv
module dtlb_spr_decode
  import dtlb_pkg::*;
#(
  parameter int          SPR_AW    = 16,
  parameter int          IDX_BITS  = 6,
  parameter int unsigned TAGW_BASE = 32'h0A00,
  parameter int unsigned XLW_BASE  = 32'h0B00
) (
  input  logic [SPR_AW-1:0]   addr,
  output spr_sel_e            sel,
  output logic [IDX_BITS-1:0] idx
);

  localparam int WIN_W = SPR_AW - IDX_BITS;
  localparam logic [WIN_W-1:0] TAGW_WIN = WIN_W'(TAGW_BASE >> IDX_BITS);
  localparam logic [WIN_W-1:0] XLW_WIN  = WIN_W'(XLW_BASE >> IDX_BITS);

  logic [WIN_W-1:0] win;

  always_comb begin
    win = addr[SPR_AW-1:IDX_BITS];
    idx = addr[IDX_BITS-1:0];
    if (win == TAGW_WIN) begin
      sel = SEL_TAGW;
    end else if (win == XLW_WIN) begin
      sel = SEL_XLW;
    end else begin
      sel = SEL_NONE;
    end
  end

endmodule

// File: rtl/dtlb_store.sv
module dtlb_store
  import dtlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 13,
  parameter int PPN_W   = 19,
  localparam int IDX_BITS = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_tagw,
  input  logic                wr_xlw,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [TAG_W-1:0]    w_tag,
  input  logic                w_valid,
  input  logic [PPN_W-1:0]    w_ppn,
  input  perm_t               w_perm,
  input  logic                w_ci,
  input  logic [IDX_BITS-1:0] sp_idx,
  output logic [TAG_W-1:0]    sp_tag,
  output logic                sp_valid,
  output logic [PPN_W-1:0]    sp_ppn,
  output perm_t               sp_perm,
  output logic                sp_ci,
  input  logic [IDX_BITS-1:0] lk_idx,
  output logic [TAG_W-1:0]    lk_tag,
  output logic                lk_valid,
  output logic [PPN_W-1:0]    lk_ppn,
  output perm_t               lk_perm,
  output logic                lk_ci
);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [ENTRIES-1:0] ent_sel;
  logic [ENTRIES-1:0] tagw_we;
  logic [ENTRIES-1:0] xlw_we;

  logic [TAG_W-1:0] tag_q  [ENTRIES];
  logic [PPN_W-1:0] ppn_q  [ENTRIES];
  perm_t            perm_q [ENTRIES];
  logic             ci_q   [ENTRIES];

  // Per-entry write strobes.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
    assign ent_sel[e] = (wr_idx == IDX_BITS'(e));
    assign tagw_we[e] = wr_tagw & ent_sel[e];
    assign xlw_we[e]  = wr_xlw  & ent_sel[e];
  end

  // Valid flags: the only reset state in the array.
  always_comb begin
    valid_d = (valid_q & ~tagw_we) | (tagw_we & {ENTRIES{w_valid}});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  // Payload storage: no reset, explicit clock enables per entry.
  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (tagw_we[e]) begin
        tag_q[e] <= w_tag;
      end
      if (xlw_we[e]) begin
        ppn_q[e]  <= w_ppn;
        perm_q[e] <= w_perm;
        ci_q[e]   <= w_ci;
      end
    end
  end

  // Two combinational read ports: software and lookup.
  always_comb begin
    sp_tag   = tag_q[sp_idx];
    sp_valid = valid_q[sp_idx];
    sp_ppn   = ppn_q[sp_idx];
    sp_perm  = perm_q[sp_idx];
    sp_ci    = ci_q[sp_idx];
    lk_tag   = tag_q[lk_idx];
    lk_valid = valid_q[lk_idx];
    lk_ppn   = ppn_q[lk_idx];
    lk_perm  = perm_q[lk_idx];
    lk_ci    = ci_q[lk_idx];
  end

endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup
  import dtlb_pkg::*;
#(
  parameter int TAG_W = 13,
  parameter int PPN_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [TAG_W-1:0] va_tag,
  input  logic [TAG_W-1:0] e_tag,
  input  logic             e_valid,
  input  logic [PPN_W-1:0] e_ppn,
  input  perm_t            e_perm,
  input  logic             e_ci,
  output logic             hit,
  output logic [PPN_W-1:0] ppn,
  output perm_t            perm,
  output logic             ci
);

  logic [TAG_W-1:0] vtag_q, vtag_d;
  logic [TAG_W-1:0] etag_q, etag_d;
  logic             evld_q, evld_d;
  logic [PPN_W-1:0] ppn_q, ppn_d;
  perm_t            perm_q, perm_d;
  logic             ci_q, ci_d;

  always_comb begin
    vtag_d = vtag_q;
    etag_d = etag_q;
    evld_d = evld_q;
    ppn_d  = ppn_q;
    perm_d = perm_q;
    ci_d   = ci_q;
    if (en) begin
      vtag_d = va_tag;
      etag_d = e_tag;
      evld_d = e_valid;
      ppn_d  = e_ppn;
      perm_d = e_perm;
      ci_d   = e_ci;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vtag_q <= '0;
      etag_q <= '0;
      evld_q <= 1'b0;
      ppn_q  <= '0;
      perm_q <= '0;
      ci_q   <= 1'b0;
    end else begin
      vtag_q <= vtag_d;
      etag_q <= etag_d;
      evld_q <= evld_d;
      ppn_q  <= ppn_d;
      perm_q <= perm_d;
      ci_q   <= ci_d;
    end
  end

  // Compare after the register: the array read and compare split across the edge.
  assign hit  = evld_q & (etag_q == vtag_q);
  assign ppn  = ppn_q;
  assign perm = perm_q;
  assign ci   = ci_q;

endmodule

// File: rtl/dtlb_direct.sv
module dtlb_direct
  import dtlb_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          PAGE_BITS = 13,
  parameter int          ENTRIES   = 64,
  parameter int          SPR_AW    = 16,
  parameter int unsigned TAGW_BASE = 32'h0A00,
  parameter int unsigned XLW_BASE  = 32'h0B00,
  localparam int IDX_BITS = $clog2(ENTRIES),
  localparam int TAG_W    = ADDR_W - PAGE_BITS - IDX_BITS,
  localparam int PPN_W    = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_en,
  input  logic [ADDR_W-1:0] lkp_vaddr,
  output logic              lkp_hit,
  output logic [PPN_W-1:0]  lkp_ppn,
  output logic              lkp_sup_wr,
  output logic              lkp_sup_rd,
  output logic              lkp_usr_wr,
  output logic              lkp_usr_rd,
  output logic              lkp_ci,
  input  logic              spr_cs,
  input  logic              spr_we,
  input  logic [SPR_AW-1:0] spr_addr,
  input  logic [ADDR_W-1:0] spr_wdata,
  output logic [ADDR_W-1:0] spr_rdata
);

  spr_sel_e            sel;
  logic [IDX_BITS-1:0] sp_idx;
  logic                wr_tagw, wr_xlw;

  logic [TAG_W-1:0]    sp_tag, lk_tag;
  logic                sp_valid, lk_valid;
  logic [PPN_W-1:0]    sp_ppn, lk_ppn;
  perm_t               sp_perm, lk_perm, w_perm, out_perm;
  logic                sp_ci, lk_ci;

  logic [IDX_BITS-1:0] va_idx;
  logic [TAG_W-1:0]    va_tag;
  logic [ADDR_W-1:0]   rd_fmt;

  logic unused_bits;
  assign unused_bits = ^{lkp_vaddr[PAGE_BITS-1:0],
                         spr_wdata[PAGE_BITS-1:XLW_SW_BIT+1],
                         spr_wdata[XLW_UR_BIT-1:XLW_CI_BIT+1]};

  dtlb_spr_decode #(
    .SPR_AW   (SPR_AW),
    .IDX_BITS (IDX_BITS),
    .TAGW_BASE(TAGW_BASE),
    .XLW_BASE (XLW_BASE)
  ) u_dec (
    .addr(spr_addr),
    .sel (sel),
    .idx (sp_idx)
  );

  assign wr_tagw = spr_cs & spr_we & (sel == SEL_TAGW);
  assign wr_xlw  = spr_cs & spr_we & (sel == SEL_XLW);

  assign w_perm.sw = spr_wdata[XLW_SW_BIT];
  assign w_perm.sr = spr_wdata[XLW_SR_BIT];
  assign w_perm.uw = spr_wdata[XLW_UW_BIT];
  assign w_perm.ur = spr_wdata[XLW_UR_BIT];

  assign va_idx = lkp_vaddr[PAGE_BITS +: IDX_BITS];
  assign va_tag = lkp_vaddr[ADDR_W-1 -: TAG_W];

  dtlb_store #(
    .ENTRIES(ENTRIES),
    .TAG_W  (TAG_W),
    .PPN_W  (PPN_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_tagw (wr_tagw),
    .wr_xlw  (wr_xlw),
    .wr_idx  (sp_idx),
    .w_tag   (spr_wdata[ADDR_W-1 -: TAG_W]),
    .w_valid (spr_wdata[TAGW_VALID_BIT]),
    .w_ppn   (spr_wdata[ADDR_W-1 -: PPN_W]),
    .w_perm  (w_perm),
    .w_ci    (spr_wdata[XLW_CI_BIT]),
    .sp_idx  (sp_idx),
    .sp_tag  (sp_tag),
    .sp_valid(sp_valid),
    .sp_ppn  (sp_ppn),
    .sp_perm (sp_perm),
    .sp_ci   (sp_ci),
    .lk_idx  (va_idx),
    .lk_tag  (lk_tag),
    .lk_valid(lk_valid),
    .lk_ppn  (lk_ppn),
    .lk_perm (lk_perm),
    .lk_ci   (lk_ci)
  );

  dtlb_lookup #(
    .TAG_W(TAG_W),
    .PPN_W(PPN_W)
  ) u_lkp (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (lkp_en),
    .va_tag (va_tag),
    .e_tag  (lk_tag),
    .e_valid(lk_valid),
    .e_ppn  (lk_ppn),
    .e_perm (lk_perm),
    .e_ci   (lk_ci),
    .hit    (lkp_hit),
    .ppn    (lkp_ppn),
    .perm   (out_perm),
    .ci     (lkp_ci)
  );

  assign lkp_sup_wr = out_perm.sw;
  assign lkp_sup_rd = out_perm.sr;
  assign lkp_usr_wr = out_perm.uw;
  assign lkp_usr_rd = out_perm.ur;

  // Rebuild the addressed word; unstored bits stay zero.
  always_comb begin
    rd_fmt = '0;
    case (sel)
      SEL_TAGW: begin
        rd_fmt[ADDR_W-1 -: TAG_W]  = sp_tag;
        rd_fmt[TAGW_VALID_BIT]     = sp_valid;
      end
      SEL_XLW: begin
        rd_fmt[ADDR_W-1 -: PPN_W]  = sp_ppn;
        rd_fmt[XLW_SW_BIT]         = sp_perm.sw;
        rd_fmt[XLW_SR_BIT]         = sp_perm.sr;
        rd_fmt[XLW_UW_BIT]         = sp_perm.uw;
        rd_fmt[XLW_UR_BIT]         = sp_perm.ur;
        rd_fmt[XLW_CI_BIT]         = sp_ci;
      end
      default: rd_fmt = '0;
    endcase
  end

  assign spr_rdata = (spr_cs && !spr_we) ? rd_fmt : '0;

endmodule

// File: rtl/dtlb_direct_chk.sv
module dtlb_direct_chk #(
  parameter int          ADDR_W    = 32,
  parameter int          PPN_W     = 19,
  parameter int          SPR_AW    = 16,
  parameter int          IDX_BITS  = 6,
  parameter int unsigned TAGW_BASE = 32'h0A00,
  parameter int unsigned XLW_BASE  = 32'h0B00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lkp_en,
  input logic              lkp_hit,
  input logic [PPN_W-1:0]  lkp_ppn,
  input logic              lkp_sup_wr,
  input logic              lkp_sup_rd,
  input logic              lkp_usr_wr,
  input logic              lkp_usr_rd,
  input logic              lkp_ci,
  input logic              spr_cs,
  input logic              spr_we,
  input logic [SPR_AW-1:0] spr_addr,
  input logic [ADDR_W-1:0] spr_wdata,
  input logic [ADDR_W-1:0] spr_rdata
);

  localparam int WIN_W = SPR_AW - IDX_BITS;
  localparam logic [WIN_W-1:0] TAGW_WIN = WIN_W'(TAGW_BASE >> IDX_BITS);
  localparam logic [WIN_W-1:0] XLW_WIN  = WIN_W'(XLW_BASE >> IDX_BITS);

  logic armed_q;
  logic seen_valid_q;
  logic in_tagw, in_xlw;

  assign in_tagw = (spr_addr[SPR_AW-1:IDX_BITS] == TAGW_WIN);
  assign in_xlw  = (spr_addr[SPR_AW-1:IDX_BITS] == XLW_WIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q      <= 1'b0;
      seen_valid_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (spr_cs && spr_we && in_tagw && spr_wdata[0]) begin
        seen_valid_q <= 1'b1;
      end
    end
  end

  // R1: no hit before a valid tag word has been written
  p_no_early_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_hit |-> seen_valid_q);

  // R5: outputs hold while the enable was low
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(lkp_en)) |->
      $stable({lkp_hit, lkp_ppn, lkp_sup_wr, lkp_sup_rd, lkp_usr_wr, lkp_usr_rd, lkp_ci}));

  // R6: unstored tag-word bits read as zero
  p_tagw_layout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_cs && !spr_we && in_tagw) |-> (spr_rdata[18:1] == '0));

  // R7: unstored translation-word bits read as zero
  p_xlw_layout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_cs && !spr_we && in_xlw) |->
      (spr_rdata[12:10] == '0 && spr_rdata[5:2] == '0 && spr_rdata[0] == 1'b0));

  // R9: read data quiet when idle, writing or outside the windows
  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!spr_cs || spr_we) |-> (spr_rdata == '0));

  p_rdata_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_tagw && !in_xlw) |-> (spr_rdata == '0));

endmodule

bind dtlb_direct dtlb_direct_chk #(
  .ADDR_W   (ADDR_W),
  .PPN_W    (PPN_W),
  .SPR_AW   (SPR_AW),
  .IDX_BITS (IDX_BITS),
  .TAGW_BASE(TAGW_BASE),
  .XLW_BASE (XLW_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lkp_en    (lkp_en),
  .lkp_hit   (lkp_hit),
  .lkp_ppn   (lkp_ppn),
  .lkp_sup_wr(lkp_sup_wr),
  .lkp_sup_rd(lkp_sup_rd),
  .lkp_usr_wr(lkp_usr_wr),
  .lkp_usr_rd(lkp_usr_rd),
  .lkp_ci    (lkp_ci),
  .spr_cs    (spr_cs),
  .spr_we    (spr_we),
  .spr_addr  (spr_addr),
  .spr_wdata (spr_wdata),
  .spr_rdata (spr_rdata)
);

// File: tb/sim_dtlb_direct.sv
`timescale 1ns/1ps
module sim_dtlb_direct;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lkp_en;
  logic [31:0] lkp_vaddr;
  logic        lkp_hit;
  logic [18:0] lkp_ppn;
  logic        lkp_sup_wr, lkp_sup_rd, lkp_usr_wr, lkp_usr_rd, lkp_ci;
  logic        spr_cs, spr_we;
  logic [15:0] spr_addr;
  logic [31:0] spr_wdata;
  logic [31:0] spr_rdata;

  always #5 clk = ~clk;

  dtlb_direct u0 (
    .clk(clk), .rst_n(rst_n), .lkp_en(lkp_en), .lkp_vaddr(lkp_vaddr),
    .lkp_hit(lkp_hit), .lkp_ppn(lkp_ppn), .lkp_sup_wr(lkp_sup_wr),
    .lkp_sup_rd(lkp_sup_rd), .lkp_usr_wr(lkp_usr_wr), .lkp_usr_rd(lkp_usr_rd),
    .lkp_ci(lkp_ci), .spr_cs(spr_cs), .spr_we(spr_we), .spr_addr(spr_addr),
    .spr_wdata(spr_wdata), .spr_rdata(spr_rdata)
  );

  int n_vec = 0;
  int n_bad = 0;

  // Reference model, built from the requirements.
  logic        m_valid [64];
  logic [12:0] m_tag   [64];
  logic [18:0] m_ppn   [64];
  logic [3:0]  m_perm  [64];   // {sw,sr,uw,ur}
  logic        m_ci    [64];

  typedef struct {
    logic [24:0] v;   // {hit, ppn[18:0], sw, sr, uw, ur, ci}
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  logic [24:0] held = '0;

  function automatic logic [24:0] outs_now();
    return {lkp_hit, lkp_ppn, lkp_sup_wr, lkp_sup_rd, lkp_usr_wr, lkp_usr_rd, lkp_ci};
  endfunction

  function automatic logic [24:0] predict(input logic [31:0] va);
    logic [5:0] ix;
    ix = va[18:13];
    return {m_valid[ix] && (m_tag[ix] == va[31:19]), m_ppn[ix], m_perm[ix], m_ci[ix]};
  endfunction

  function automatic logic [31:0] mk_tagw(input logic [12:0] t, input logic v);
    return {t, 18'b0, v};
  endfunction

  function automatic logic [31:0] mk_xlw(input logic [18:0] p, input logic [3:0] pm, input logic c);
    return {p, 3'b0, pm, 4'b0, c, 1'b0};
  endfunction

  function automatic logic [31:0] mk_va(input logic [12:0] t, input logic [5:0] ix, input logic [12:0] off);
    return {t, ix, off};
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [31:0] d);
    if (a[15:6] == 10'h028) begin
      m_tag[a[5:0]]   = d[31:19];
      m_valid[a[5:0]] = d[0];
    end else if (a[15:6] == 10'h02C) begin
      m_ppn[a[5:0]]  = d[31:13];
      m_perm[a[5:0]] = d[9:6];
      m_ci[a[5:0]]   = d[1];
    end
  endtask

  // Scoreboard monitor: one result per clock, sampled mid low phase.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_vec++;
      if (outs_now() !== e.v) begin
        n_bad++;
        $display("FAIL %s lookup outputs act=%h exp=%h", e.req, outs_now(), e.v);
      end
    end
  end

  // Driver: one clock slot, starting just after a falling edge.
  task automatic cycle(input logic le, input logic [31:0] va,
                       input logic we, input logic [15:0] a, input logic [31:0] d,
                       input string req);
    exp_t e;
    lkp_en    = le;
    lkp_vaddr = va;
    spr_cs    = we;
    spr_we    = we;
    spr_addr  = a;
    spr_wdata = d;
    if (le) held = predict(va);   // old contents: prediction before the write (R10)
    e.v   = held;
    e.req = req;
    @(posedge clk);
    #1;
    sb_q.push_back(e);
    if (we) model_write(a, d);
    @(negedge clk);
    lkp_en = 1'b0;
    spr_cs = 1'b0;
    spr_we = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input string req);
    cycle(1'b1, va, 1'b0, 16'h0, 32'h0, req);
  endtask

  task automatic swrite(input logic [15:0] a, input logic [31:0] d, input string req);
    cycle(1'b0, 32'h0, 1'b1, a, d, req);
  endtask

  task automatic sread(input logic [15:0] a, input logic cs, input logic [31:0] exp, input string req);
    spr_cs   = cs;
    spr_we   = 1'b0;
    spr_addr = a;
    #2;
    n_vec++;
    if (spr_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s spr read addr=%h act=%h exp=%h", req, a, spr_rdata, exp);
    end
    spr_cs = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_valid[i] = 1'b0;
    rst_n = 1'b0; lkp_en = 1'b0; lkp_vaddr = '0;
    spr_cs = 1'b0; spr_we = 1'b0; spr_addr = '0; spr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of the lookup outputs
    n_vec++;
    if (outs_now() !== 25'h0) begin
      n_bad++;
      $display("FAIL R1 reset outputs act=%h exp=%h", outs_now(), 25'h0);
    end

    // R1: translation written but tag word never validated -> no hit, fields still returned (R4)
    swrite(16'h0B05, mk_xlw(19'h43210, 4'b1010, 1'b1), "R7");
    lookup(mk_va(13'h1A5, 6'd5, 13'h0), "R1");

    // R2/R4: valid entry hits, fields follow
    swrite(16'h0A05, mk_tagw(13'h1A5, 1'b1), "R6");
    lookup(mk_va(13'h1A5, 6'd5, 13'h0000), "R2");
    lookup(mk_va(13'h1A5, 6'd5, 13'h1FFF), "R2 offset ignored");
    lookup(mk_va(13'h1A4, 6'd5, 13'h0123), "R3 tag mismatch");

    // R5: enable low, address wandering
    cycle(1'b0, mk_va(13'h1A4, 6'd5, 13'h0), 1'b0, 16'h0, 32'h0, "R5 hold");
    cycle(1'b0, 32'hFFFF_FFFF, 1'b0, 16'h0, 32'h0, "R5 hold");

    // Boundary entries 0 and 63
    swrite(16'h0B00, mk_xlw(19'h7FFFF, 4'b1111, 1'b0), "R7");
    swrite(16'h0A00, mk_tagw(13'h0000, 1'b1), "R6");
    swrite(16'h0B3F, mk_xlw(19'h00001, 4'b0101, 1'b1), "R7");
    swrite(16'h0A3F, mk_tagw(13'h1FFF, 1'b1), "R6");
    lookup(mk_va(13'h0000, 6'd0, 13'h0042), "R4 entry0");
    lookup(mk_va(13'h1FFF, 6'd63, 13'h1000), "R4 entry63");
    lookup(mk_va(13'h1A5, 6'd5, 13'h0008), "R2 back-to-back");
    lookup(mk_va(13'h1FFE, 6'd63, 13'h0), "R3 entry63 mismatch");

    // R3: tag equal but valid clear
    swrite(16'h0B09, mk_xlw(19'h2AAAA, 4'b0011, 1'b0), "R7");
    swrite(16'h0A09, mk_tagw(13'h0007, 1'b0), "R6");
    lookup(mk_va(13'h0007, 6'd9, 13'h0), "R3 invalid");

    // R6/R7 read-back layouts
    sread(16'h0A05, 1'b1, mk_tagw(13'h1A5, 1'b1), "R6");
    sread(16'h0A09, 1'b1, mk_tagw(13'h0007, 1'b0), "R6");
    sread(16'h0B05, 1'b1, mk_xlw(19'h43210, 4'b1010, 1'b1), "R7");
    sread(16'h0B3F, 1'b1, mk_xlw(19'h00001, 4'b0101, 1'b1), "R7");

    // R8: tag-word write leaves its translation word and neighbours alone
    swrite(16'h0A05, mk_tagw(13'h00FF, 1'b1), "R8");
    sread(16'h0B05, 1'b1, mk_xlw(19'h43210, 4'b1010, 1'b1), "R8");
    sread(16'h0A00, 1'b1, mk_tagw(13'h0000, 1'b1), "R8");
    sread(16'h0B3F, 1'b1, mk_xlw(19'h00001, 4'b0101, 1'b1), "R8");
    lookup(mk_va(13'h00FF, 6'd5, 13'h0), "R8 new tag hits");

    // R9: quiet read data and ignored out-of-window writes
    sread(16'h0A05, 1'b0, 32'h0, "R9 cs low");
    sread(16'h0A40, 1'b1, 32'h0, "R9 above tag window");
    sread(16'h0B45, 1'b1, 32'h0, "R9 above xlate window");
    sread(16'h0C05, 1'b1, 32'h0, "R9 other page");
    swrite(16'h0A45, mk_tagw(13'h0123, 1'b0), "R9");
    swrite(16'h1B05, mk_xlw(19'h11111, 4'b0000, 1'b0), "R9");
    sread(16'h0A05, 1'b1, mk_tagw(13'h00FF, 1'b1), "R9 write ignored");
    sread(16'h0B05, 1'b1, mk_xlw(19'h43210, 4'b1010, 1'b1), "R9 write ignored");
    lookup(mk_va(13'h00FF, 6'd5, 13'h0), "R9 entry intact");

    // R10: lookup and write to the same entry on one edge
    cycle(1'b1, mk_va(13'h1FFF, 6'd63, 13'h0), 1'b1, 16'h0A3F, mk_tagw(13'h0ABC, 1'b1), "R10 old contents");
    lookup(mk_va(13'h1FFF, 6'd63, 13'h0), "R10 old tag now misses");
    lookup(mk_va(13'h0ABC, 6'd63, 13'h0), "R10 new tag hits");
    cycle(1'b1, mk_va(13'h0000, 6'd0, 13'h0), 1'b1, 16'h0B00, mk_xlw(19'h12345, 4'b1000, 1'b1), "R10 old fields");
    lookup(mk_va(13'h0000, 6'd0, 13'h0), "R10 new fields");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule